// File: doc/BRIEF.md
# Quad-Phase Fetch/Execute Cycle Sequencer

This block sequences a small two-stage processor core. It runs from an oscillator clock and divides every instruction cycle into four phases, Q1 to Q4. It holds the program counter, a prefetch latch and the instruction register. While one instruction executes, the word that follows it is being fetched. Steady-state throughput is therefore one instruction per instruction cycle.

Program memory is read combinationally at `pm_addr`, and the word returned is latched as Q4 closes. That word becomes the instruction at the edge that closes the next Q1. At the same edge the program counter moves forward. Execution is split across the phases:

- the data operand is read in Q2;
- an external ALU is enabled in Q3;
- the result is written back in Q4.

A jump loads a new program counter. It throws away the word already prefetched, so one no-op bubble cycle follows the jump.

Instruction words are `IW` bits wide. The opcode sits in the top four bits. The low bits carry either a data address or a jump target.

Top module: `qseq_top`

## Requirements
- R1: While reset is held low, and in the first phase after it is released, `phase` is 4'b0001 (Q1), `pm_addr` is 0, `ir_word` is 0, and `dm_rd`, `alu_en` and `dm_wr` are all low.
- R2: `phase` is one-hot and advances one step per clock, in the order bit0 (Q1), bit1 (Q2), bit2 (Q3), bit3 (Q4), then back to bit0.
- R3: `pm_addr` can change only at the clock edge that closes a Q1 phase. Outside jumps and the first cycle after reset, that edge advances it by exactly 1.
- R4: The word on `pm_rdata` when Q4 closes appears on `ir_word` from the edge that closes the next Q1. It stays there for Q2, Q3, Q4 and the following Q1.
- R5: For opcodes 2 to 15 (bits [15:12] of the word), `dm_rd` is high during Q2 only. During that phase `dm_addr` equals instruction bits [7:0].
- R6: For opcodes 2 to 15, `alu_en` is high during Q3 only. `alu_a` then holds the value `dm_rdata` had when Q2 closed, and `alu_op` carries the opcode.
- R7: For opcodes 3 to 15, `dm_wr` is high during Q4 only, and `dm_wdata` carries the `alu_result` captured when Q3 closed. Opcode 2 reads but never writes.
- R8: Opcode 0 (no-op) and opcode 1 (jump) raise none of `dm_rd`, `alu_en` or `dm_wr`.
- R9: Opcode 1 is a jump. At the Q1 edge that ends its execution, `pm_addr` is loaded with instruction bits [9:0] and `ir_word` becomes 0. The word already prefetched is discarded.
- R10: The first instruction cycle after reset executes a no-op and fetches address 0. The word at address 0 executes in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, four ticks per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_addr | output | PC_W | Program memory address (program counter) |
| pm_rdata | input | IW | Program memory read word |
| dm_addr | output | DA_W | Data memory address from the instruction |
| dm_rd | output | 1 | Operand read strobe (Q2) |
| dm_rdata | input | DW | Data memory read value |
| dm_wr | output | 1 | Destination write strobe (Q4) |
| dm_wdata | output | DW | Write-back data |
| alu_op | output | 4 | Opcode of the executing instruction |
| alu_en | output | 1 | ALU execute strobe (Q3) |
| alu_a | output | DW | Latched operand presented to the ALU |
| alu_result | input | DW | ALU result |
| phase | output | 4 | One-hot phase, bit0 = Q1 |
| ir_word | output | IW | Instruction register contents |

## Verification
A phase counter that slips or stalls shows up within one oscillator tick as a misplaced or missing strobe, or as a `phase` pattern out of order. A wrong program counter or prefetch value reaches `ir_word` one instruction cycle later, when the bad word is executed. A branch that keeps the stale prefetched word instead of inserting the bubble shows up in the very next Q2 as a data strobe that should not be there. A stale operand or result latch appears as a wrong `alu_a` in Q3 or a wrong `dm_wdata` in Q4 of the same instruction.

// File: rtl/qseq_pkg.sv
package qseq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    CLS_IDLE,
    CLS_BRANCH,
    CLS_PEEK,
    CLS_RMW
  } op_class_e;

  localparam int unsigned OPC_W = 4;

  // next phase in the Q1..Q4 rotation
  function automatic phase_e phase_after(input phase_e p);
    logic [1:0] v;
    v = p;
    v = v + 2'd1;
    return phase_e'(v);
  endfunction

  // opcode to behaviour class: 0 idle, 1 branch, 2 read-only, rest read-modify-write
  function automatic op_class_e classify(input logic [31:0] opc);
    if (opc == 32'd0) return CLS_IDLE;
    if (opc == 32'd1) return CLS_BRANCH;
    if (opc == 32'd2) return CLS_PEEK;
    return CLS_RMW;
  endfunction

endpackage

// File: rtl/qseq_phase_gen.sv
module qseq_phase_gen
  import qseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output phase_e     ph,
  output logic [3:0] ph_onehot
);

  phase_e ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_Q1;
    else        ph_q <= phase_after(ph_q);
  end

  assign ph = ph_q;

  for (genvar g = 0; g < 4; g++) begin : g_dec
    assign ph_onehot[g] = (ph_q == phase_e'(2'(g)));
  end

endmodule

// File: rtl/qseq_fetch.sv
module qseq_fetch
  import qseq_pkg::*;
#(
  parameter int unsigned IW   = 16,
  parameter int unsigned PC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  phase_e          ph,
  input  logic [IW-1:0]   pm_rdata,
  output logic [PC_W-1:0] pc,
  output logic [IW-1:0]   ir,
  output logic            ev_pc_step,
  output logic            ev_branch
);

  logic [IW-1:0]   prefetch_q;
  logic [IW-1:0]   ir_q;
  logic [PC_W-1:0] pc_q;
  logic            started_q;
  logic            ir_is_branch;

  function automatic logic [PC_W-1:0] pc_next_seq(input logic [PC_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [PC_W-1:0] jump_target(input logic [IW-1:0] w);
    return w[PC_W-1:0];
  endfunction

  assign ir_is_branch = (classify(32'(ir_q[IW-1 -: OPC_W])) == CLS_BRANCH);
  assign ev_branch    = (ph == PH_Q1) && ir_is_branch;
  assign ev_pc_step   = (ph == PH_Q1) && started_q && !ir_is_branch;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prefetch_q <= '0;
      ir_q       <= '0;
      pc_q       <= '0;
      started_q  <= 1'b0;
    end else begin
      if (ph == PH_Q4) prefetch_q <= pm_rdata;
      if (ph == PH_Q1) begin
        started_q <= 1'b1;
        if (ir_is_branch) begin
          pc_q <= jump_target(ir_q);
          ir_q <= '0;
        end else begin
          ir_q <= prefetch_q;
          if (started_q) pc_q <= pc_next_seq(pc_q);
        end
      end
    end
  end

  assign pc = pc_q;
  assign ir = ir_q;

endmodule

// File: rtl/qseq_exec.sv
module qseq_exec
  import qseq_pkg::*;
#(
  parameter int unsigned DA_W = 8,
  parameter int unsigned DW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           ph,
  input  logic [OPC_W-1:0] opc,
  input  logic [DA_W-1:0]  addr_field,
  input  logic [DW-1:0]    dm_rdata,
  input  logic [DW-1:0]    alu_result,
  output logic [DA_W-1:0]  dm_addr,
  output logic             dm_rd,
  output logic             dm_wr,
  output logic [DW-1:0]    dm_wdata,
  output logic             alu_en,
  output logic [DW-1:0]    alu_a
);

  op_class_e cls;
  logic      touches_data;
  logic [DW-1:0] operand_q;
  logic [DW-1:0] result_q;

  assign cls          = classify(32'(opc));
  assign touches_data = (cls == CLS_PEEK) || (cls == CLS_RMW);

  assign dm_addr = addr_field;
  assign dm_rd   = (ph == PH_Q2) && touches_data;
  assign alu_en  = (ph == PH_Q3) && touches_data;
  assign dm_wr   = (ph == PH_Q4) && (cls == CLS_RMW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      operand_q <= '0;
      result_q  <= '0;
    end else begin
      if (dm_rd)  operand_q <= dm_rdata;
      if (alu_en) result_q  <= alu_result;
    end
  end

  assign alu_a    = operand_q;
  assign dm_wdata = result_q;

endmodule

// File: rtl/qseq_top.sv
module qseq_top
  import qseq_pkg::*;
#(
  parameter int unsigned IW   = 16,
  parameter int unsigned PC_W = 10,
  parameter int unsigned DA_W = 8,
  parameter int unsigned DW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PC_W-1:0]  pm_addr,
  input  logic [IW-1:0]    pm_rdata,
  output logic [DA_W-1:0]  dm_addr,
  output logic             dm_rd,
  input  logic [DW-1:0]    dm_rdata,
  output logic             dm_wr,
  output logic [DW-1:0]    dm_wdata,
  output logic [OPC_W-1:0] alu_op,
  output logic             alu_en,
  output logic [DW-1:0]    alu_a,
  input  logic [DW-1:0]    alu_result,
  output logic [3:0]       phase,
  output logic [IW-1:0]    ir_word
);

  localparam int unsigned OPC_LSB = IW - OPC_W;

  phase_e ph;
  logic   ev_pc_step;
  logic   ev_branch;

  qseq_phase_gen u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .ph        (ph),
    .ph_onehot (phase)
  );

  qseq_fetch #(.IW(IW), .PC_W(PC_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph         (ph),
    .pm_rdata   (pm_rdata),
    .pc         (pm_addr),
    .ir         (ir_word),
    .ev_pc_step (ev_pc_step),
    .ev_branch  (ev_branch)
  );

  assign alu_op = ir_word[OPC_LSB +: OPC_W];

  qseq_exec #(.DA_W(DA_W), .DW(DW)) u_exec (
    .clk        (clk),
    .rst_n      (rst_n),
    .ph         (ph),
    .opc        (ir_word[OPC_LSB +: OPC_W]),
    .addr_field (ir_word[DA_W-1:0]),
    .dm_rdata   (dm_rdata),
    .alu_result (alu_result),
    .dm_addr    (dm_addr),
    .dm_rd      (dm_rd),
    .dm_wr      (dm_wr),
    .dm_wdata   (dm_wdata),
    .alu_en     (alu_en),
    .alu_a      (alu_a)
  );

endmodule

// File: rtl/qseq_chk.sv
module qseq_chk #(
  parameter int unsigned PC_W = 10,
  parameter int unsigned DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0]      phase,
  input logic [PC_W-1:0] pm_addr,
  input logic [PC_W-1:0] ir_target,
  input logic            ir_zero,
  input logic            dm_rd,
  input logic            dm_wr,
  input logic            alu_en,
  input logic [DW-1:0]   dm_wdata,
  input logic [DW-1:0]   alu_result,
  input logic            ev_pc_step,
  input logic            ev_branch
);

  p_phase_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  p_phase_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == {$past(phase[2:0]), $past(phase[3])});

  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phase[0] |=> $stable(pm_addr));

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pc_step |=> pm_addr == PC_W'($past(pm_addr) + 1'b1));

  p_branch_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> pm_addr == $past(ir_target));

  p_branch_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_branch |=> ir_zero);

  p_rd_in_q2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dm_rd |-> phase[1]);

  p_alu_in_q3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |-> phase[2]);

  p_wr_in_q4_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr |-> phase[3]);

  p_wdata_from_alu_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dm_wr |-> dm_wdata == $past(alu_result));

endmodule

bind qseq_top qseq_chk #(.PC_W(PC_W), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (phase),
  .pm_addr    (pm_addr),
  .ir_target  (ir_word[PC_W-1:0]),
  .ir_zero    (ir_word == '0),
  .dm_rd      (dm_rd),
  .dm_wr      (dm_wr),
  .alu_en     (alu_en),
  .dm_wdata   (dm_wdata),
  .alu_result (alu_result),
  .ev_pc_step (ev_pc_step),
  .ev_branch  (ev_branch)
);

// File: tb/qseq_top_tb_top.sv
module qseq_top_tb_top;
  localparam int IW = 16, PC_W = 10, DA_W = 8, DW = 8;

  // {expect_read, expect_write, instruction word}
  localparam logic [17:0] VEC [8] = '{
    {2'b00, 16'h0000},
    {2'b10, 16'h2011},
    {2'b11, 16'h3022},
    {2'b11, 16'hF0FF},
    {2'b11, 16'h7080},
    {2'b10, 16'h20AA},
    {2'b00, 16'h0000},
    {2'b11, 16'h4001}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [PC_W-1:0] pm_addr;
  logic [IW-1:0]   pm_rdata;
  logic [DA_W-1:0] dm_addr;
  logic            dm_rd, dm_wr, alu_en;
  logic [DW-1:0]   dm_rdata, dm_wdata, alu_a, alu_result;
  logic [3:0]      alu_op, phase;
  logic [IW-1:0]   ir_word;
  logic [IW-1:0]   prog [16];

  assign pm_rdata   = (pm_addr < PC_W'(16)) ? prog[pm_addr[3:0]] : '0;
  assign dm_rdata   = dm_addr ^ 8'h5A;
  assign alu_result = alu_a + {4'b0000, alu_op};

  qseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .dm_addr(dm_addr), .dm_rd(dm_rd), .dm_rdata(dm_rdata), .dm_wr(dm_wr),
    .dm_wdata(dm_wdata), .alu_op(alu_op), .alu_en(alu_en), .alu_a(alu_a),
    .alu_result(alu_result), .phase(phase), .ir_word(ir_word)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check_idle(input string req);
    chk(req, "dm_rd", dm_rd, 0);
    chk(req, "alu_en", alu_en, 0);
    chk(req, "dm_wr", dm_wr, 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "phase in reset", phase, 4'b0001);
    chk("R1", "pm_addr in reset", pm_addr, 0);
    chk("R1", "ir_word in reset", ir_word, 0);
    check_idle("R1");
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) prog[i] = '0;
    for (int i = 0; i < 8; i++) prog[i] = VEC[i][15:0];
    do_reset();

    // cycle 0: released, Q1
    chk("R1", "phase after release", phase, 4'b0001);
    chk("R1", "pm_addr after release", pm_addr, 0);
    step();
    chk("R2", "phase Q2", phase, 4'b0010);
    chk("R10", "no pc step in first cycle", pm_addr, 0);
    chk("R10", "first cycle is no-op", ir_word, 0);
    check_idle("R10");
    step();
    chk("R2", "phase Q3", phase, 4'b0100);
    step();
    chk("R2", "phase Q4", phase, 4'b1000);
    step();
    chk("R2", "phase wraps to Q1", phase, 4'b0001);

    // vector walk: word n executes in cycle n+1
    for (int n = 0; n < 8; n++) begin
      logic [IW-1:0] w;
      logic [3:0] op;
      logic [DW-1:0] rdv, wv;
      w   = VEC[n][15:0];
      op  = w[15:12];
      rdv = w[7:0] ^ 8'h5A;
      wv  = rdv + {4'b0000, op};
      chk("R3", "pm_addr held in Q1", pm_addr, (n == 0) ? 0 : n);
      step(); // Q2
      chk("R4", "ir_word", ir_word, w);
      chk("R3", "pm_addr after step", pm_addr, n + 1);
      chk("R5", "dm_rd in Q2", dm_rd, VEC[n][17]);
      if (VEC[n][17]) chk("R5", "dm_addr", dm_addr, w[7:0]);
      chk("R6", "alu_en off in Q2", alu_en, 0);
      chk("R7", "dm_wr off in Q2", dm_wr, 0);
      step(); // Q3
      chk("R6", "alu_en in Q3", alu_en, VEC[n][17]);
      chk("R5", "dm_rd off in Q3", dm_rd, 0);
      if (VEC[n][17]) begin
        chk("R6", "alu_a", alu_a, rdv);
        chk("R6", "alu_op", alu_op, op);
      end
      step(); // Q4
      chk("R7", "dm_wr in Q4", dm_wr, VEC[n][16]);
      chk("R6", "alu_en off in Q4", alu_en, 0);
      if (VEC[n][16]) chk("R7", "dm_wdata", dm_wdata, wv);
      step(); // next Q1
      chk("R4", "ir_word held in Q1", ir_word, w);
      check_idle("R2");
    end

    // jump and bubble
    for (int i = 0; i < 16; i++) prog[i] = '0;
    prog[0] = 16'h3005;
    prog[1] = 16'h1008;
    prog[2] = 16'h3033;
    prog[8] = 16'h2044;
    do_reset();
    repeat (4) step();        // cycle 1 Q1
    step();                   // cycle 1 Q2
    chk("R10", "word 0 in second cycle", ir_word, 16'h3005);
    repeat (4) step();        // cycle 2 Q2
    chk("R8", "jump in ir", ir_word, 16'h1008);
    chk("R8", "jump dm_rd", dm_rd, 0);
    step();
    chk("R8", "jump alu_en", alu_en, 0);
    step();
    chk("R8", "jump dm_wr", dm_wr, 0);
    step();                   // cycle 3 Q1
    chk("R3", "pm_addr held before jump edge", pm_addr, 2);
    step();                   // cycle 3 Q2
    chk("R9", "pm_addr jump target", pm_addr, 8);
    chk("R9", "bubble ir", ir_word, 0);
    chk("R9", "discarded word no read", dm_rd, 0);
    step();
    chk("R9", "bubble alu_en", alu_en, 0);
    step();
    chk("R9", "bubble dm_wr", dm_wr, 0);
    step();                   // cycle 4 Q1
    step();                   // cycle 4 Q2
    chk("R9", "target word executes", ir_word, 16'h2044);
    chk("R3", "pm_addr after target", pm_addr, 9);
    chk("R5", "target dm_rd", dm_rd, 1);
    chk("R5", "target dm_addr", dm_addr, 8'h44);
    step();
    step();                   // Q4 of peek
    chk("R7", "peek no write", dm_wr, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule